// File: doc/BRIEF.md
# SD/MMC Command Launch Sequencer

This block sits between a host register interface and the card-side command engine of an SD/MMC controller. When the host strobes `start_i`, the block captures the command word, the argument and two shadow configuration vectors: a clock-control vector and a transfer-control vector. It then hands them to the card clock domain through a toggle request/acknowledge handshake.

In the card domain the captured command becomes one of two actions. The first is a plain settings update: the clock-control vector is copied across, the card clock stays gated and nothing is sent on any line. The second is a command launch. The transfer-control vector is copied across. An optional run of 80 idle-high clocks can precede the command. The 48-bit command frame is then shifted out on the command line of one selected card, and a completion pulse follows. When the stop/abort flag is set, that pulse also tells the data engine to return to idle.

The host keeps `busy_o` high until the card domain acknowledges. A strobe that arrives while busy is dropped and recorded.

Top module: `sdcmd_launch`

## Requirements
- R1: After reset, `busy_o`, `busy_err_o`, `card_err_o`, `cclk_en_o`, `cmd_oe_o`, `done_o`, `abort_o`, `clk_cfg_o` and `xfer_cfg_o` are all 0, and every bit of `cmd_o` is 1.
- R2: A launched command is driven MSB first, one bit per card clock while `cclk_en_o` is 1, as the 48-bit frame {0, 1, index = command word bits 5:0, 32-bit argument, seven 0 bits, 1}.
- R3: When command word bit 15 is 1, exactly 80 card clocks with the line at 1 and `cclk_en_o` at 1 precede the frame.
- R4: When command word bit 15 is 0, the frame begins in the first enabled card clock, with no preamble.
- R5: `done_o` is 1 for exactly one card clock, in the card clock right after the end bit, and `cclk_en_o` is 0 in that clock.
- R6: When command word bit 21 is 1, `clk_cfg_o` takes the captured clock-control vector, `xfer_cfg_o` is unchanged, `cclk_en_o` stays 0 and `done_o` does not pulse. When bit 21 is 0, `clk_cfg_o` is unchanged.
- R7: A launched command (bit 21 = 0) copies the captured transfer-control vector to `xfer_cfg_o` by the time `done_o` pulses.
- R8: When command word bit 14 is 1, `abort_o` pulses together with `done_o`. When bit 14 is 0, `abort_o` stays 0.
- R9: Command word bits 20:16 select the card: only `cmd_oe_o[card]` is 1 during the sequence, and every other `cmd_o` bit stays 1.
- R10: With `sd_mode_i` = 1, a start whose card number is 16 or above is rejected. Nothing is launched, `busy_o` stays 0 and the sticky flag `card_err_o` sets. With `sd_mode_i` = 0 the same number is accepted.
- R11: A start strobe while `busy_o` is 1 is ignored: no second sequence is launched and the sticky flag `busy_err_o` sets.
- R12: `busy_o` rises in the host clock after an accepted start and stays 1 until the acknowledge returns from the card domain, so it is still 1 while `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| start_i | input | 1 | Launch strobe, one host clock |
| cmd_word_i | input | 32 | Command word (flags, card number, index) |
| cmd_arg_i | input | 32 | Command argument |
| clk_cfg_i | input | CLK_CFG_W | Shadow clock-control vector |
| xfer_cfg_i | input | XFER_CFG_W | Shadow transfer-control vector |
| sd_mode_i | input | 1 | 1 limits card numbers to 0..15 |
| busy_o | output | 1 | Launch in progress |
| busy_err_o | output | 1 | Sticky: strobe arrived while busy |
| card_err_o | output | 1 | Sticky: card number rejected |
| cclk | input | 1 | Card-domain clock |
| crst_n | input | 1 | Card-domain reset, active low |
| cclk_en_o | output | 1 | Card clock enable (preamble and frame) |
| cmd_o | output | NCARD | Per-card command line, idle 1 |
| cmd_oe_o | output | NCARD | Per-card command line drive enable |
| done_o | output | 1 | Command-done pulse |
| abort_o | output | 1 | Return-to-idle pulse for the data engine |
| clk_cfg_o | output | CLK_CFG_W | Clock-control vector in the card domain |
| xfer_cfg_o | output | XFER_CFG_W | Transfer-control vector in the card domain |

## Verification
The bench counts every enabled card clock and checks the exact 80 + 48 and 48 lengths. A preamble one clock short or long, or one that does not depend on bit 15, shows up as a wrong count or a shifted frame. It issues a clock-only update and checks that the card clock never enables and no done pulse appears; a design that treated bit 21 as a normal command would emit a frame or a completion. It tries card 20 with SD mode on and then off, so a missing or inverted range check shows up as a rejected legal card or a launched illegal one. It also strobes during a busy launch and checks that the queued frame is the first command, so a design that re-captured the word mid-flight would send the second command's bits.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
    localparam int FRAME_W   = 48;
    localparam int INIT_CLKS = 80;
    localparam int IDX_W     = 6;
    localparam int CARD_W    = 5;
    localparam int ARG_W     = 32;
    localparam int CRC_W     = 7;
    localparam int STOP_POS  = 14;
    localparam int INIT_POS  = 15;
    localparam int CARD_LSB  = 16;
    localparam int UPD_POS   = 21;
    localparam int CNT_W     = $clog2(INIT_CLKS);

    typedef enum logic [1:0] {CS_IDLE, CS_PRE, CS_FRAME, CS_DONE} card_st_e;

    typedef struct packed {
        logic              stop;
        logic              init;
        logic              upd;
        logic [CARD_W-1:0] card;
        logic [IDX_W-1:0]  idx;
    } cmd_fields_t;

    function automatic cmd_fields_t decode_word(input logic [31:0] w);
        cmd_fields_t f;
        f.stop = w[STOP_POS];
        f.init = w[INIT_POS];
        f.upd  = w[UPD_POS];
        f.card = w[CARD_LSB +: CARD_W];
        f.idx  = w[IDX_W-1:0];
        return f;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [IDX_W-1:0] idx,
                                                       input logic [ARG_W-1:0] arg);
        return {1'b0, 1'b1, idx, arg, {CRC_W{1'b0}}, 1'b1};
    endfunction
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdl_host_ctrl.sv
module sdl_host_ctrl
    import sdl_pkg::*;
#(
    parameter int CLK_CFG_W  = 16,
    parameter int XFER_CFG_W = 64,
    parameter int CARD_LIMIT = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [31:0]           cmd_word_i,
    input  logic [ARG_W-1:0]      cmd_arg_i,
    input  logic [CLK_CFG_W-1:0]  clk_cfg_i,
    input  logic [XFER_CFG_W-1:0] xfer_cfg_i,
    input  logic                  sd_mode_i,
    input  logic                  ack_sync_i,
    output logic                  req_tgl_o,
    output cmd_fields_t           hold_fields_o,
    output logic [ARG_W-1:0]      hold_arg_o,
    output logic [CLK_CFG_W-1:0]  hold_clk_o,
    output logic [XFER_CFG_W-1:0] hold_xfer_o,
    output logic                  busy_o,
    output logic                  busy_err_o,
    output logic                  card_err_o
);
    typedef struct packed {
        logic                  req_tgl;
        logic                  busy;
        logic                  busy_err;
        logic                  card_err;
        cmd_fields_t           fields;
        logic [ARG_W-1:0]      arg;
        logic [CLK_CFG_W-1:0]  clk_cfg;
        logic [XFER_CFG_W-1:0] xfer_cfg;
    } host_st_t;

    host_st_t    st_d, st_q;
    cmd_fields_t in_f;
    logic        out_of_range;

    always_comb begin
        st_d         = st_q;
        in_f         = decode_word(cmd_word_i);
        out_of_range = sd_mode_i && (int'(in_f.card) >= CARD_LIMIT);
        if (st_q.busy && (ack_sync_i == st_q.req_tgl)) begin
            st_d.busy = 1'b0;
        end
        if (start_i) begin
            if (st_q.busy) begin
                st_d.busy_err = 1'b1;
            end else if (out_of_range) begin
                st_d.card_err = 1'b1;
            end else begin
                st_d.fields   = in_f;
                st_d.arg      = cmd_arg_i;
                st_d.clk_cfg  = clk_cfg_i;
                st_d.xfer_cfg = xfer_cfg_i;
                st_d.req_tgl  = ~st_q.req_tgl;
                st_d.busy     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl_o     = st_q.req_tgl;
    assign hold_fields_o = st_q.fields;
    assign hold_arg_o    = st_q.arg;
    assign hold_clk_o    = st_q.clk_cfg;
    assign hold_xfer_o   = st_q.xfer_cfg;
    assign busy_o        = st_q.busy;
    assign busy_err_o    = st_q.busy_err;
    assign card_err_o    = st_q.card_err;

    p_busy_strobe_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> busy_err_o);
    p_busy_strobe_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(req_tgl_o));
    p_reject_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && out_of_range) |=> (card_err_o && !busy_o));
    p_busy_until_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (ack_sync_i == req_tgl_o));
endmodule

// File: rtl/sdl_card_seq.sv
module sdl_card_seq
    import sdl_pkg::*;
#(
    parameter int NCARD      = 32,
    parameter int CLK_CFG_W  = 16,
    parameter int XFER_CFG_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_sync_i,
    input  cmd_fields_t           fields_i,
    input  logic [ARG_W-1:0]      arg_i,
    input  logic [CLK_CFG_W-1:0]  clk_cfg_i,
    input  logic [XFER_CFG_W-1:0] xfer_cfg_i,
    output logic                  ack_tgl_o,
    output logic                  cclk_en_o,
    output logic [NCARD-1:0]      cmd_o,
    output logic [NCARD-1:0]      cmd_oe_o,
    output logic                  done_o,
    output logic                  abort_o,
    output logic [CLK_CFG_W-1:0]  clk_cfg_o,
    output logic [XFER_CFG_W-1:0] xfer_cfg_o
);
    typedef struct packed {
        card_st_e              st;
        logic                  seen;
        logic                  ack;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_W-1:0]    shreg;
        logic [CARD_W-1:0]     card;
        logic                  stop;
        logic                  done;
        logic                  abort;
        logic [CLK_CFG_W-1:0]  clk_cfg;
        logic [XFER_CFG_W-1:0] xfer_cfg;
    } card_st_t;

    card_st_t st_d, st_q;
    logic     line_bit;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.abort = 1'b0;
        unique case (st_q.st)
            CS_IDLE: begin
                if (req_sync_i != st_q.seen) begin
                    st_d.seen = req_sync_i;
                    if (fields_i.upd) begin
                        st_d.clk_cfg = clk_cfg_i;
                        st_d.ack     = ~st_q.ack;
                    end else begin
                        st_d.xfer_cfg = xfer_cfg_i;
                        st_d.card     = fields_i.card;
                        st_d.stop     = fields_i.stop;
                        st_d.shreg    = build_frame(fields_i.idx, arg_i);
                        if (fields_i.init) begin
                            st_d.st  = CS_PRE;
                            st_d.cnt = CNT_W'(INIT_CLKS - 1);
                        end else begin
                            st_d.st  = CS_FRAME;
                            st_d.cnt = CNT_W'(FRAME_W - 1);
                        end
                    end
                end
            end
            CS_PRE: begin
                if (st_q.cnt == '0) begin
                    st_d.st  = CS_FRAME;
                    st_d.cnt = CNT_W'(FRAME_W - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            CS_FRAME: begin
                st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b1};
                if (st_q.cnt == '0) begin
                    st_d.st    = CS_DONE;
                    st_d.done  = 1'b1;
                    st_d.abort = st_q.stop;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            CS_DONE: begin
                st_d.ack = ~st_q.ack;
                st_d.st  = CS_IDLE;
            end
            default: st_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cclk_en_o  = (st_q.st == CS_PRE) || (st_q.st == CS_FRAME);
    assign line_bit   = (st_q.st == CS_FRAME) ? st_q.shreg[FRAME_W-1] : 1'b1;
    assign ack_tgl_o  = st_q.ack;
    assign done_o     = st_q.done;
    assign abort_o    = st_q.abort;
    assign clk_cfg_o  = st_q.clk_cfg;
    assign xfer_cfg_o = st_q.xfer_cfg;

    for (genvar gi = 0; gi < NCARD; gi++) begin : g_line
        assign cmd_oe_o[gi] = cclk_en_o && (st_q.card == CARD_W'(gi));
        assign cmd_o[gi]    = cmd_oe_o[gi] ? line_bit : 1'b1;
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cclk_en_o && $past(cclk_en_o)));
    p_abort_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> done_o);
    p_one_card_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_oe_o));
    p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cclk_en_o |-> ((cmd_oe_o == '0) && (&cmd_o)));
    p_clk_cfg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en_o |=> $stable(clk_cfg_o));
endmodule

// File: rtl/sdcmd_launch.sv
module sdcmd_launch
    import sdl_pkg::*;
#(
    parameter int NCARD      = 32,
    parameter int CLK_CFG_W  = 16,
    parameter int XFER_CFG_W = 64,
    parameter int CARD_LIMIT = 16,
    parameter int SYNC_STG   = 2
) (
    input  logic                  hclk,
    input  logic                  hrst_n,
    input  logic                  start_i,
    input  logic [31:0]           cmd_word_i,
    input  logic [31:0]           cmd_arg_i,
    input  logic [CLK_CFG_W-1:0]  clk_cfg_i,
    input  logic [XFER_CFG_W-1:0] xfer_cfg_i,
    input  logic                  sd_mode_i,
    output logic                  busy_o,
    output logic                  busy_err_o,
    output logic                  card_err_o,
    input  logic                  cclk,
    input  logic                  crst_n,
    output logic                  cclk_en_o,
    output logic [NCARD-1:0]      cmd_o,
    output logic [NCARD-1:0]      cmd_oe_o,
    output logic                  done_o,
    output logic                  abort_o,
    output logic [CLK_CFG_W-1:0]  clk_cfg_o,
    output logic [XFER_CFG_W-1:0] xfer_cfg_o
);
    logic                  req_tgl, req_sync, ack_tgl, ack_sync;
    cmd_fields_t           hold_fields;
    logic [ARG_W-1:0]      hold_arg;
    logic [CLK_CFG_W-1:0]  hold_clk;
    logic [XFER_CFG_W-1:0] hold_xfer;

    sdl_host_ctrl #(
        .CLK_CFG_W (CLK_CFG_W),
        .XFER_CFG_W(XFER_CFG_W),
        .CARD_LIMIT(CARD_LIMIT)
    ) u_host (
        .clk          (hclk),
        .rst_n        (hrst_n),
        .start_i      (start_i),
        .cmd_word_i   (cmd_word_i),
        .cmd_arg_i    (cmd_arg_i),
        .clk_cfg_i    (clk_cfg_i),
        .xfer_cfg_i   (xfer_cfg_i),
        .sd_mode_i    (sd_mode_i),
        .ack_sync_i   (ack_sync),
        .req_tgl_o    (req_tgl),
        .hold_fields_o(hold_fields),
        .hold_arg_o   (hold_arg),
        .hold_clk_o   (hold_clk),
        .hold_xfer_o  (hold_xfer),
        .busy_o       (busy_o),
        .busy_err_o   (busy_err_o),
        .card_err_o   (card_err_o)
    );

    sdl_sync #(.STAGES(SYNC_STG)) u_req_sync (
        .clk(cclk), .rst_n(crst_n), .d_i(req_tgl), .q_o(req_sync)
    );

    sdl_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk(hclk), .rst_n(hrst_n), .d_i(ack_tgl), .q_o(ack_sync)
    );

    sdl_card_seq #(
        .NCARD     (NCARD),
        .CLK_CFG_W (CLK_CFG_W),
        .XFER_CFG_W(XFER_CFG_W)
    ) u_card (
        .clk       (cclk),
        .rst_n     (crst_n),
        .req_sync_i(req_sync),
        .fields_i  (hold_fields),
        .arg_i     (hold_arg),
        .clk_cfg_i (hold_clk),
        .xfer_cfg_i(hold_xfer),
        .ack_tgl_o (ack_tgl),
        .cclk_en_o (cclk_en_o),
        .cmd_o     (cmd_o),
        .cmd_oe_o  (cmd_oe_o),
        .done_o    (done_o),
        .abort_o   (abort_o),
        .clk_cfg_o (clk_cfg_o),
        .xfer_cfg_o(xfer_cfg_o)
    );
endmodule

// File: tb/tb_sdcmd_launch.sv
module tb_sdcmd_launch;
    localparam int NCARD = 32;
    localparam int CW    = 16;
    localparam int XW    = 64;

    logic hclk = 0, cclk = 0, hrst_n = 0, crst_n = 0;
    logic start_i = 0, sd_mode_i = 0;
    logic [31:0] cmd_word_i = '0, cmd_arg_i = '0;
    logic [CW-1:0] clk_cfg_i = '0;
    logic [XW-1:0] xfer_cfg_i = '0;
    logic busy_o, busy_err_o, card_err_o, cclk_en_o, done_o, abort_o;
    logic [NCARD-1:0] cmd_o, cmd_oe_o;
    logic [CW-1:0] clk_cfg_o;
    logic [XW-1:0] xfer_cfg_o;

    always #4  hclk = ~hclk;
    always #10 cclk = ~cclk;

    sdcmd_launch dut (.*);

    typedef struct {
        int           card;
        bit           init;
        bit           stop;
        logic [47:0]  frame;
        logic [XW-1:0] xfer;
    } exp_t;

    exp_t exp_q[$];
    int errors = 0, checks = 0, done_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(bit upd, int card, bit init, bit stop, int idx);
        logic [31:0] w = '0;
        w[21] = upd; w[20:16] = card[4:0]; w[15] = init; w[14] = stop; w[5:0] = idx[5:0];
        return w;
    endfunction

    task automatic strobe(input logic [31:0] w, input logic [31:0] a,
                          input logic [CW-1:0] c, input logic [XW-1:0] x);
        @(negedge hclk);
        cmd_word_i = w; cmd_arg_i = a; clk_cfg_i = c; xfer_cfg_i = x; start_i = 1;
        @(negedge hclk);
        start_i = 0;
    endtask

    task automatic issue(input int card, input bit init, input bit stop, input int idx,
                         input logic [31:0] a, input logic [XW-1:0] x);
        exp_t e;
        e.card = card; e.init = init; e.stop = stop; e.xfer = x;
        e.frame = {1'b0, 1'b1, 6'(idx), a, 7'd0, 1'b1};
        exp_q.push_back(e);
        strobe(mk_word(0, card, init, stop, idx), a, 16'hFFFF, x);
    endtask

    task automatic wait_idle();
        @(negedge hclk);
        while (busy_o) @(negedge hclk);
        repeat (4) @(negedge cclk);
    endtask

    // monitor: pops expected items and compares the produced sequences
    initial begin
        exp_t e;
        logic [127:0] buf_v;
        int n;
        wait (crst_n);
        forever begin
            @(negedge cclk);
            if (cclk_en_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6/R10/R11 unexpected sequence", 1, 0);
                    e.card = 0; e.init = 0; e.stop = 0; e.frame = '0; e.xfer = '0;
                end else e = exp_q.pop_front();
                n = 0; buf_v = '0;
                while (cclk_en_o) begin
                    buf_v = {buf_v[126:0], cmd_o[e.card]};
                    n++;
                    if (cmd_oe_o != (NCARD'(1) << e.card) || (&(cmd_o | (NCARD'(1) << e.card))) !== 1'b1)
                        chk(0, "R9 card select", cmd_oe_o, NCARD'(1) << e.card);
                    @(negedge cclk);
                end
                chk(n == (e.init ? 128 : 48), e.init ? "R3 preamble+frame length" : "R4 frame length no preamble", n, e.init ? 128 : 48);
                chk(buf_v[47:0] == e.frame, "R2 frame bits", buf_v[47:0], e.frame);
                if (e.init) chk(buf_v[127:48] == {80{1'b1}}, "R3 preamble ones", buf_v[127:64], '1);
                chk(done_o == 1'b1, "R5 done after end bit", done_o, 1);
                chk(abort_o == e.stop, "R8 abort with done", abort_o, e.stop);
                chk(busy_o == 1'b1, "R12 busy held until ack", busy_o, 1);
                chk(xfer_cfg_o == e.xfer, "R7 transfer config copied", xfer_cfg_o, e.xfer);
                done_cnt++;
                @(negedge cclk);
                chk(done_o == 1'b0, "R5 done single cycle", done_o, 0);
            end else if (done_o) begin
                chk(0, "R6 unexpected done", 1, 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge hclk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int dc;
        repeat (3) @(negedge cclk);
        hrst_n = 1; crst_n = 1;
        @(negedge hclk);
        // R1 reset state
        chk(!busy_o && !busy_err_o && !card_err_o, "R1 host flags", {busy_o, busy_err_o, card_err_o}, 0);
        chk(!cclk_en_o && cmd_oe_o == '0 && &cmd_o, "R1 lines idle", cmd_o, '1);
        chk(!done_o && !abort_o && clk_cfg_o == '0 && xfer_cfg_o == '0, "R1 card outputs", xfer_cfg_o, 0);

        // R2 R4 R7 R9: plain command on card 3
        issue(3, 0, 0, 17, 32'hDEADBEEF, 64'h1111_2222_3333_4444);
        wait_idle();
        // R3 preamble on card 0
        issue(0, 1, 0, 0, 32'h0000_01AA, 64'h5);
        wait_idle();
        // R8 stop/abort on card 5
        issue(5, 0, 1, 12, 32'h8000_0001, 64'hABCD);
        wait_idle();
        chk(clk_cfg_o == '0, "R6 clock config untouched by commands", clk_cfg_o, 0);

        // R6 clock-only update
        dc = done_cnt;
        strobe(mk_word(1, 7, 1, 0, 3), 32'h0, 16'h5A3C, 64'h9999);
        wait_idle();
        chk(clk_cfg_o == 16'h5A3C, "R6 clock config copied", clk_cfg_o, 16'h5A3C);
        chk(xfer_cfg_o == 64'hABCD, "R6 transfer config kept", xfer_cfg_o, 64'hABCD);
        chk(done_cnt == dc, "R6 no done", done_cnt, dc);

        // R10 out-of-range card in SD mode
        sd_mode_i = 1;
        strobe(mk_word(0, 20, 0, 0, 9), 32'h1234, 16'h0, 64'h7);
        repeat (2) @(negedge hclk);
        chk(card_err_o == 1'b1, "R10 card error flag", card_err_o, 1);
        chk(busy_o == 1'b0, "R10 not launched", busy_o, 0);
        repeat (20) @(negedge cclk);
        chk(done_cnt == dc, "R10 no sequence", done_cnt, dc);
        // card 15 is legal in SD mode
        issue(15, 0, 0, 2, 32'h0F0F0F0F, 64'h15);
        wait_idle();
        sd_mode_i = 0;
        issue(20, 0, 0, 9, 32'h1234, 64'h7);
        wait_idle();
        chk(card_err_o == 1'b1, "R10 card error sticky", card_err_o, 1);

        // R11 strobe while busy
        issue(31, 1, 0, 63, 32'hCAFEF00D, 64'h31);
        repeat (3) @(negedge hclk);
        chk(busy_o == 1'b1, "R12 busy after accept", busy_o, 1);
        strobe(mk_word(0, 2, 0, 1, 5), 32'h0BAD0BAD, 16'h0, 64'hBAD);
        @(negedge hclk);
        chk(busy_err_o == 1'b1, "R11 busy error flag", busy_err_o, 1);
        wait_idle();
        repeat (100) @(negedge cclk);
        chk(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);
        chk(done_cnt == dc + 3, "R11 single launch", done_cnt, dc + 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule